// File: doc/BRIEF.md
# Finite Difference Polynomial Tabulator

This block tabulates an integer polynomial with additions only. Software, or a neighbouring block, writes a seed value and up to six seed differences into a bank of registers while the block is idle. A start request then runs the tabulation for a chosen number of entries. On every clock of the run the block shows one table entry together with its index, and then moves all registers one step along the difference chain. The top-order difference never changes. Each lower register gains the old contents of the register one order above it, and the value register gains the old first difference.

All arithmetic is 32-bit two's complement and wraps modulo 2^32. A sticky flag records whether any signed addition overflowed during the current run. The registers keep their state when a run ends, so a later start with no reload carries on from where the last run stopped.

Top module: `fdt_tabulator`

## Requirements
- R1: After reset, busy, out_valid and ovf are 0, and out_value and out_index are 0. All seven registers read as 0.
- R2: A write with ld_en=1 while idle stores ld_data in the register chosen by ld_sel. Code 0 selects the value register and codes 1 to 6 select the difference of that order. Code 7 selects nothing and has no effect.
- R3: A start accepted with run_len=N>0 raises busy and out_valid in the next cycle. Both stay high for exactly N consecutive cycles and then fall.
- R4: The first entry of a run is the value register. Between consecutive entries, value_next = value + d1 and dk_next = dk + d(k+1) for k=1..5, all using the old values, while d6 stays fixed. Seeds 41,2,2 give 41,43,47,53,61, and seeds 0,1,62,540,1560,1800,720 give n^6.
- R5: out_index is 0 on the first entry of a run and rises by 1 on each following entry.
- R6: Writes presented while busy is high change no register.
- R7: start is ignored while busy. A start with run_len=0 is also ignored and leaves the block idle.
- R8: Additions wrap modulo 2^32, so 0xFFFFFFFF plus 1 gives 0.
- R9: ovf is cleared when a start is accepted. It is set by any step in which a signed addition in any register overflows, and it stays set until the next accepted start. A wrap with no signed overflow leaves it at 0.
- R10: A run leaves the registers stepped N-1 times. A new start with no reload shows the last entry of the previous run as its first entry, at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Register write strobe |
| ld_sel | input | 3 | Register select: 0 value, 1..6 difference order |
| ld_data | input | 32 | Write data |
| start | input | 1 | Run request |
| run_len | input | 16 | Number of entries for the run |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | out_value holds a table entry |
| out_value | output | 32 | Current table entry |
| out_index | output | 16 | Index of the entry on out_value |
| ovf | output | 1 | Sticky signed overflow flag for the current run |

## Verification
Each difference order reaches the output through the orders below it. A corrupted first difference therefore shows up in the entry right after the corruption. A corrupted d(k) shows up k entries later, so the degree-six sequence has to run for at least seven entries to reach the constant top register, and the bench runs it for ten. Control errors show up sooner. A wrong step count, a missed index increment or an accepted stray write alters the entry count or an entry within the same run. A missed clear or set of ovf shows on the flag at the end of that run.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_st_t;
endpackage

// File: rtl/fdt_ld_dec.sv
module fdt_ld_dec #(
  parameter int NREG = 7,
  parameter int SELW = 3
) (
  input  logic            ld_en,
  input  logic [SELW-1:0] ld_sel,
  input  logic            busy,
  output logic [NREG-1:0] we
);
  for (genvar k = 0; k < NREG; k++) begin : g_we
    assign we[k] = ld_en & ~busy & (ld_sel == SELW'(k));
  end
endmodule

// File: rtl/fdt_stage.sv
module fdt_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  input  logic             adv,
  input  logic [WIDTH-1:0] addend,
  output logic [WIDTH-1:0] q,
  output logic             ovf
);
  logic [WIDTH-1:0] q_r, q_d, sum;
  logic             en;

  // next state
  always_comb begin
    sum = q_r + addend;
    en  = we | adv;
    q_d = we ? wdata : sum;
    ovf = adv & (q_r[WIDTH-1] == addend[WIDTH-1]) & (sum[WIDTH-1] != q_r[WIDTH-1]);
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;

  // R6: a step and a load never coincide
  p_load_excl_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !we);
endmodule

// File: rtl/fdt_seq.sv
module fdt_seq
  import fdt_pkg::*;
#(
  parameter int IDXW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IDXW-1:0] run_len,
  input  logic            step_ovf,
  output logic            busy,
  output logic            adv,
  output logic [IDXW-1:0] index,
  output logic            ovf
);
  run_st_t         st_q, st_d;
  logic [IDXW-1:0] rem_q, rem_d, idx_q, idx_d;
  logic            ovf_q, ovf_d, accept, last;

  // next state
  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    idx_d  = idx_q;
    ovf_d  = ovf_q;
    accept = (st_q == ST_IDLE) && start && (run_len != '0);
    last   = (rem_q == IDXW'(1));
    adv    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_RUN;
          rem_d = run_len;
          idx_d = '0;
          ovf_d = 1'b0;
        end
      end
      ST_RUN: begin
        if (last) begin
          st_d = ST_IDLE;
        end else begin
          adv   = 1'b1;
          rem_d = rem_q - IDXW'(1);
          idx_d = idx_q + IDXW'(1);
          ovf_d = ovf_q | step_ovf;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      idx_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      idx_q <= idx_d;
      ovf_q <= ovf_d;
    end
  end

  assign busy  = (st_q == ST_RUN);
  assign index = idx_q;
  assign ovf   = ovf_q;

  p_first_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (index == '0));
  p_index_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (index == $past(index) + IDXW'(1)));
  p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ovf);
  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && run_len == '0) |=> !busy);
endmodule

// File: rtl/fdt_tabulator.sv
module fdt_tabulator #(
  parameter int WIDTH = 32,
  parameter int NDIFF = 6,
  parameter int IDXW  = 16,
  localparam int NREG = NDIFF + 1,
  localparam int SELW = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SELW-1:0]  ld_sel,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             start,
  input  logic [IDXW-1:0]  run_len,
  output logic             busy,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_value,
  output logic [IDXW-1:0]  out_index,
  output logic             ovf
);
  logic [1:0]       rs_q;
  logic             rst_i;
  logic [NREG-1:0]  we;
  logic [NREG-1:0]  st_ovf;
  logic [WIDTH-1:0] r_q [NREG];
  logic             adv, busy_i;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  fdt_ld_dec #(.NREG(NREG), .SELW(SELW)) u_dec (
    .ld_en (ld_en),
    .ld_sel(ld_sel),
    .busy  (busy_i),
    .we    (we)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_chain
    logic [WIDTH-1:0] add_k;
    if (k == NREG - 1) begin : g_top
      assign add_k = '0;
    end else begin : g_mid
      assign add_k = r_q[k+1];
    end
    fdt_stage #(.WIDTH(WIDTH)) u_stage (
      .clk   (clk),
      .rst_n (rst_i),
      .we    (we[k]),
      .wdata (ld_data),
      .adv   (adv),
      .addend(add_k),
      .q     (r_q[k]),
      .ovf   (st_ovf[k])
    );
  end

  fdt_seq #(.IDXW(IDXW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (start),
    .run_len (run_len),
    .step_ovf(|st_ovf),
    .busy    (busy_i),
    .adv     (adv),
    .index   (out_index),
    .ovf     (ovf)
  );

  assign busy      = busy_i;
  assign out_valid = busy_i;
  assign out_value = r_q[0];

  p_value_step_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && $past(out_valid)) |-> (out_value == $past(out_value + r_q[1])));
  p_top_hold_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (busy_i && $past(busy_i)) |-> (r_q[NREG-1] == $past(r_q[NREG-1])));
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_i |-> (!busy && !ovf));
endmodule

// File: tb/test_fdt_tabulator.sv
`timescale 1ns/100ps
module test_fdt_tabulator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [2:0]  ld_sel;
  logic [31:0] ld_data;
  logic        start;
  logic [15:0] run_len;
  logic        busy, out_valid, ovf;
  logic [31:0] out_value;
  logic [15:0] out_index;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  logic [31:0] q_val[$];
  logic [15:0] q_idx[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  fdt_tabulator i_fdt_tabulator (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .start(start), .run_len(run_len), .busy(busy), .out_valid(out_valid),
    .out_value(out_value), .out_index(out_index), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // monitor: pops one expected entry per valid cycle
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      vcount++;
      if (q_val.size() == 0) begin
        chk(1'b0, "R3 unexpected entry", longint'(out_value), 0);
      end else begin
        logic [31:0] ev;
        logic [15:0] ei;
        string       et;
        ev = q_val.pop_front();
        ei = q_idx.pop_front();
        et = q_tag.pop_front();
        chk(out_value == ev, {et, " value"}, longint'(out_value), longint'(ev));
        chk(out_index == ei, "R5 index", longint'(out_index), longint'(ei));
      end
    end
  end

  task automatic push_exp(input logic [31:0] v, input logic [15:0] i, input string tag);
    q_val.push_back(v);
    q_idx.push_back(i);
    q_tag.push_back(tag);
  endtask

  task automatic load(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all(input logic [31:0] a0, a1, a2, a3, a4, a5, a6);
    load(3'd0, a0); load(3'd1, a1); load(3'd2, a2); load(3'd3, a3);
    load(3'd4, a4); load(3'd5, a5); load(3'd6, a6);
  endtask

  task automatic kick(input logic [15:0] n);
    @(negedge clk);
    start = 1'b1; run_len = n;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run(input int n, input string tag);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(vcount == n, {tag, " entry count"}, vcount, n);
    chk(q_val.size() == 0, {tag, " leftover expected"}, q_val.size(), 0);
    vcount = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_sel = '0; ld_data = '0; start = 1'b0; run_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !out_valid, "R1 busy/valid", {busy, out_valid}, 0);
    chk(out_value == 0 && out_index == 0, "R1 value/index", out_value, 0);
    chk(!ovf, "R1 ovf", ovf, 0);

    // R4 quadratic table, R3 timing
    load_all(41, 2, 2, 0, 0, 0, 0);
    push_exp(41, 0, "R4"); push_exp(43, 1, "R4"); push_exp(47, 2, "R4");
    push_exp(53, 3, "R4"); push_exp(61, 4, "R4");
    kick(5);
    chk(out_valid && busy, "R3 valid after start", out_valid, 1);
    finish_run(5, "R3");
    chk(!ovf, "R9 no overflow", ovf, 0);

    // R10 continuation without reload
    push_exp(61, 0, "R10"); push_exp(71, 1, "R10"); push_exp(83, 2, "R10");
    kick(3);
    finish_run(3, "R10");

    // R4 sixth-degree: n^6
    load_all(0, 1, 62, 540, 1560, 1800, 720);
    for (int n = 0; n < 10; n++) push_exp(32'(n**6), 16'(n), "R4 deg6");
    kick(10);
    finish_run(10, "R4");

    // R6 writes during a run are ignored
    load_all(41, 2, 2, 0, 0, 0, 0);
    push_exp(41, 0, "R6"); push_exp(43, 1, "R6"); push_exp(47, 2, "R6");
    push_exp(53, 3, "R6"); push_exp(61, 4, "R6");
    kick(5);
    load(3'd0, 999);
    load(3'd1, 7);
    finish_run(5, "R6");

    // R7 start while busy ignored
    push_exp(61, 0, "R7"); push_exp(71, 1, "R7"); push_exp(83, 2, "R7"); push_exp(97, 3, "R7");
    kick(4);
    start = 1'b1; run_len = 9;
    @(negedge clk);
    start = 1'b0;
    finish_run(4, "R7");
    // R7 zero length
    kick(0);
    chk(!busy && !out_valid, "R7 zero length start", busy, 0);
    @(negedge clk);
    chk(!busy, "R7 zero length stays idle", busy, 0);

    // R2 code 7 writes nothing
    load(3'd7, 12345);
    push_exp(97, 0, "R2 sel7"); push_exp(113, 1, "R2 sel7");
    kick(2);
    finish_run(2, "R2");
    // R2 direct load
    load_all(100, 5, 0, 0, 0, 0, 0);
    push_exp(100, 0, "R2"); push_exp(105, 1, "R2"); push_exp(110, 2, "R2");
    kick(3);
    finish_run(3, "R2");

    // R8 wrap without signed overflow
    load_all(32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0);
    push_exp(32'hFFFF_FFFF, 0, "R8"); push_exp(0, 1, "R8"); push_exp(1, 2, "R8");
    kick(3);
    finish_run(3, "R8");
    chk(!ovf, "R9 unsigned wrap no ovf", ovf, 0);
    load_all(5, 32'hFFFF_FFFD, 0, 0, 0, 0, 0);
    push_exp(5, 0, "R8 neg"); push_exp(2, 1, "R8 neg"); push_exp(32'hFFFF_FFFF, 2, "R8 neg");
    kick(3);
    finish_run(3, "R8");

    // R9 overflow in value register
    load_all(32'h7FFF_FFF0, 32'h10, 0, 0, 0, 0, 0);
    push_exp(32'h7FFF_FFF0, 0, "R9"); push_exp(32'h8000_0000, 1, "R9");
    push_exp(32'h8000_0010, 2, "R9");
    kick(3);
    finish_run(3, "R9");
    chk(ovf, "R9 ovf set", ovf, 1);
    // R9 cleared by the next accepted start
    push_exp(32'h8000_0010, 0, "R9 clear");
    kick(1);
    finish_run(1, "R9");
    chk(!ovf, "R9 ovf cleared", ovf, 0);
    // R9 overflow in a difference register
    load_all(0, 32'h7FFF_FFFF, 1, 0, 0, 0, 0);
    push_exp(0, 0, "R9 diff"); push_exp(32'h7FFF_FFFF, 1, "R9 diff");
    kick(2);
    finish_run(2, "R9");
    chk(ovf, "R9 diff ovf set", ovf, 1);

    summary();
    $finish;
  end
endmodule